// File: doc/BRIEF.md
# Banked Peripheral Region Remap Register

This block holds the setting that routes one naturally aligned window of the physical address space to a peripheral port. It also decides, for every address presented, whether that address falls inside the window. The setting is a 32-bit word. Its upper twenty bits give the window base. Its low five bits give a logarithmic size code, and the bits in between are unused. Two independent copies are kept, one for the secure world and one for the non-secure world. The security-state input picks the copy that an access reaches and the copy that the matcher uses.

Register accesses are single-cycle with no flow control. A request is presented with `acc_en`. Read data and the `undef` flag are valid combinationally in the same cycle. A permitted write lands on the next rising clock edge. Accesses from unprivileged code are refused. Secure writes can also be refused by an external lock input. A refused access raises `undef`, and the system turns that into an exception. The address match is purely combinational on the stored copy and on `addr`. The block reports the window size in bytes next to the hit flag.

Top module: `periph_remap_bank`

## Requirements
- R1: After reset both copies hold base 0 and size code 0, so reads of either copy return 0 and `hit` and `region_bytes` are 0 for every address.
- R2: The word layout is base in bits [31:12] and size code in bits [4:0]. Bits [11:5] always read as 0, and whatever is written to them is discarded.
- R3: Size codes 3 through 22 give `region_bytes` = 2^(code+9), from 4 KB to 2 GB. Code 0 gives `region_bytes` = 0.
- R4: Reserved codes (1, 2 and 23 to 31) are stored and read back unchanged. They still make `region_bytes` 0 and keep `hit` at 0.
- R5: With a valid code, `hit` is 1 exactly when `addr[31:code+9]` equals the same bits of the active base. Base bits below code+9 are ignored.
- R6: Any access with `priv` low raises `undef` in that cycle, returns `acc_rdata` 0 and changes neither copy.
- R7: A privileged secure write (`nonsec` low) while `sec_wr_lock` is high raises `undef` and leaves the secure copy unchanged. The lock does not refuse secure reads, and it does not affect non-secure writes.
- R8: A privileged access with `nonsec` high reads or writes only the non-secure copy, and with `nonsec` low only the secure copy. `hit` and `region_bytes` use the copy selected by `nonsec`.
- R9: `acc_rdata`, `undef`, `hit` and `region_bytes` respond combinationally. A permitted write becomes visible only after the next rising edge of `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_en | input | 1 | Register access request this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 32 | Write data word |
| acc_rdata | output | 32 | Read data word, 0 unless a permitted read |
| priv | input | 1 | Requester is privileged |
| nonsec | input | 1 | Requester and matcher are in the non-secure state |
| sec_wr_lock | input | 1 | Refuse secure writes |
| undef | output | 1 | Access refused |
| addr | input | 32 | Physical address to match |
| hit | output | 1 | `addr` is inside the active window |
| region_bytes | output | 32 | Size of the active window in bytes, 0 when none |

## Verification
A register write and an address match can occur in the same cycle. They may involve the same copy of the register or opposite copies. The bench drives both together, both in directed steps and in most random steps. In those cycles it judges `hit` and `region_bytes` against the contents stored before the write. It then checks the following cycle against the newly written contents. It also pairs a secure write under lock with a non-secure write and match, to show that one copy's refusal does not reach the other.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int ADDR_W   = 32;
  localparam int BASE_LSB = 12;
  localparam int CODE_W   = 5;
  localparam int CODE_MIN = 3;
  localparam int CODE_MAX = 22;
  localparam int CODE_OFS = 9;
  localparam int NBANK    = 2;
  localparam int SH_W     = $clog2(ADDR_W) + 1;
  localparam int GAP_W    = BASE_LSB - CODE_W;

  typedef struct packed {
    logic [ADDR_W-1:BASE_LSB] base;
    logic [CODE_W-1:0]        code;
  } remap_reg_t;
endpackage

// File: rtl/remap_access.sv
module remap_access (
  input  logic acc_en,
  input  logic acc_wr,
  input  logic priv,
  input  logic nonsec,
  input  logic sec_wr_lock,
  output logic undef,
  output logic wr_sec,
  output logic wr_ns,
  output logic rd_ok
);
  logic locked_wr;
  always_comb begin
    locked_wr = acc_wr && !nonsec && sec_wr_lock;
    undef     = acc_en && (!priv || locked_wr);
    wr_sec    = acc_en && priv && acc_wr && !nonsec && !sec_wr_lock;
    wr_ns     = acc_en && priv && acc_wr && nonsec;
    rd_ok     = acc_en && priv && !acc_wr;
  end
endmodule

// File: rtl/remap_bank.sv
module remap_bank
  import remap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_sec,
  input  logic       wr_ns,
  input  remap_reg_t wval,
  output remap_reg_t sec_q,
  output remap_reg_t ns_q
);
  remap_reg_t        store [NBANK];
  logic [NBANK-1:0]  we;

  assign we = {wr_ns, wr_sec};

  for (genvar g = 0; g < NBANK; g++) begin : g_copy
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    store[g] <= '0;
      else if (we[g]) store[g] <= wval;
    end
  end

  assign sec_q = store[0];
  assign ns_q  = store[1];
endmodule

// File: rtl/remap_match.sv
module remap_match
  import remap_pkg::*;
(
  input  remap_reg_t        cfg,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [ADDR_W-1:0] region_bytes
);
  logic              code_ok;
  logic [SH_W-1:0]   sh;
  logic [ADDR_W-1:0] mask, full_base;

  always_comb begin
    code_ok      = (cfg.code >= CODE_W'(CODE_MIN)) && (cfg.code <= CODE_W'(CODE_MAX));
    sh           = SH_W'(cfg.code) + SH_W'(CODE_OFS);
    region_bytes = code_ok ? (ADDR_W'(1) << sh) : '0;
    mask         = ~(region_bytes - ADDR_W'(1));
    full_base    = {cfg.base, {BASE_LSB{1'b0}}};
    hit          = code_ok && ((addr & mask) == (full_base & mask));
  end
endmodule

// File: rtl/periph_remap_bank.sv
module periph_remap_bank
  import remap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_wdata,
  output logic [ADDR_W-1:0] acc_rdata,
  input  logic              priv,
  input  logic              nonsec,
  input  logic              sec_wr_lock,
  output logic              undef,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [ADDR_W-1:0] region_bytes
);
  logic       wr_sec, wr_ns, rd_ok;
  remap_reg_t wval, sec_q, ns_q, active;

  remap_access u_acc (
    .acc_en(acc_en), .acc_wr(acc_wr), .priv(priv), .nonsec(nonsec),
    .sec_wr_lock(sec_wr_lock), .undef(undef), .wr_sec(wr_sec),
    .wr_ns(wr_ns), .rd_ok(rd_ok)
  );

  assign wval.base = acc_wdata[ADDR_W-1:BASE_LSB];
  assign wval.code = acc_wdata[CODE_W-1:0];

  remap_bank u_bank (
    .clk(clk), .rst_n(rst_n), .wr_sec(wr_sec), .wr_ns(wr_ns),
    .wval(wval), .sec_q(sec_q), .ns_q(ns_q)
  );

  assign active    = nonsec ? ns_q : sec_q;
  assign acc_rdata = rd_ok ? {active.base, {GAP_W{1'b0}}, active.code} : '0;

  remap_match u_match (
    .cfg(active), .addr(addr), .hit(hit), .region_bytes(region_bytes)
  );
endmodule

// File: rtl/remap_chk.sv
module remap_chk
  import remap_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              acc_en,
  input logic              acc_wr,
  input logic              priv,
  input logic              nonsec,
  input logic              sec_wr_lock,
  input logic              undef,
  input logic              hit,
  input logic [ADDR_W-1:0] acc_rdata,
  input logic [ADDR_W-1:0] region_bytes,
  input remap_reg_t        sec_q,
  input remap_reg_t        ns_q
);
  p_user_undef_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en && !priv |-> undef);

  p_user_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en && !priv |=> $stable(sec_q) && $stable(ns_q));

  p_lock_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en && acc_wr && priv && !nonsec && sec_wr_lock |=> $stable(sec_q));

  p_lock_undef_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en && acc_wr && priv && !nonsec && sec_wr_lock |-> undef);

  p_ns_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en && nonsec |=> $stable(sec_q));

  p_sec_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en && !nonsec |=> $stable(ns_q));

  p_size_pow2_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(region_bytes) <= 1);

  p_nosize_nohit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    region_bytes == '0 |-> !hit);

  p_gap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rdata[BASE_LSB-1:CODE_W] == '0);
endmodule

bind periph_remap_bank remap_chk chk_i (
  .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .priv(priv),
  .nonsec(nonsec), .sec_wr_lock(sec_wr_lock), .undef(undef), .hit(hit),
  .acc_rdata(acc_rdata), .region_bytes(region_bytes),
  .sec_q(sec_q), .ns_q(ns_q)
);

// File: tb/periph_remap_bank_tb_top.sv
module periph_remap_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_en = 1'b0, acc_wr = 1'b0, priv = 1'b0, nonsec = 1'b0, sec_wr_lock = 1'b0;
  logic [31:0] acc_wdata = '0, addr = '0;
  logic [31:0] acc_rdata, region_bytes;
  logic        undef, hit;

  int total = 0, bad = 0;
  logic [19:0] m_base [2];
  logic [4:0]  m_code [2];

  always #10 clk = ~clk;

  periph_remap_bank dut_i (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .priv(priv),
    .nonsec(nonsec), .sec_wr_lock(sec_wr_lock), .undef(undef),
    .addr(addr), .hit(hit), .region_bytes(region_bytes)
  );

  function automatic logic [31:0] exp_bytes(input logic [4:0] c);
    if (c >= 5'd3 && c <= 5'd22) return 32'd1 << (c + 5'd9);
    return 32'd0;
  endfunction

  function automatic logic exp_hit(input logic [19:0] b, input logic [4:0] c,
                                   input logic [31:0] a);
    int n;
    if (exp_bytes(c) == 0) return 1'b0;
    n = int'(c) + 9;
    return (a >> n) == ({b, 12'h000} >> n);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(input logic en, input logic wr, input logic pv, input logic ns,
                    input logic lk, input logic [31:0] wd, input logic [31:0] a,
                    input string tag);
    int i;
    logic eu, wok;
    @(negedge clk);
    acc_en = en; acc_wr = wr; priv = pv; nonsec = ns; sec_wr_lock = lk;
    acc_wdata = wd; addr = a;
    #1;
    i   = ns ? 1 : 0;
    eu  = en && (!pv || (wr && !ns && lk));
    wok = en && pv && wr && !(!ns && lk);
    chk({tag, " undef"}, {31'd0, undef}, {31'd0, eu});
    chk({tag, " rdata"}, acc_rdata,
        (en && pv && !wr) ? {m_base[i], 7'd0, m_code[i]} : 32'd0);
    chk({tag, " bytes"}, region_bytes, exp_bytes(m_code[i]));
    chk({tag, " hit"}, {31'd0, hit}, {31'd0, exp_hit(m_base[i], m_code[i], a)});
    if (wok) begin
      m_base[i] = wd[31:12];
      m_code[i] = wd[4:0];
    end
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] wd, a;
    logic [4:0]  c;
    m_base[0] = '0; m_base[1] = '0; m_code[0] = '0; m_code[1] = '0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state of both copies
    op(1, 0, 1, 0, 0, 0, 32'h0000_0000, "R1 sec");
    op(1, 0, 1, 1, 0, 0, 32'hFFFF_FFFF, "R1 ns");
    // R3 R5 R9 64KB window; same-cycle write and match see old value
    op(1, 1, 1, 0, 0, 32'h4000_0007, 32'h4000_1000, "R9 old");
    op(1, 0, 1, 0, 0, 0, 32'h4000_FFFF, "R5 in");
    op(0, 0, 1, 0, 0, 0, 32'h4001_0000, "R5 out");
    // R5 base low bits ignored
    op(1, 1, 1, 0, 0, 32'h4000_3007, 32'h4000_0000, "R5 wr");
    op(0, 0, 1, 0, 0, 0, 32'h4000_0000, "R5 lowbits");
    // R2 gap bits discarded
    op(1, 1, 1, 0, 0, 32'h1234_5FE8, 0, "R2 wr");
    op(1, 0, 1, 0, 0, 0, 32'h1234_5000, "R2 read");
    // R4 reserved codes
    op(1, 1, 1, 0, 0, 32'h0000_0002, 0, "R4 wr2");
    op(1, 0, 1, 0, 0, 0, 32'h0000_0000, "R4 c2");
    op(1, 1, 1, 0, 0, 32'h0000_0017, 0, "R4 wr23");
    op(1, 0, 1, 0, 0, 0, 32'h0000_0000, "R4 c23");
    // R3 R5 largest window 2GB
    op(1, 1, 1, 0, 0, 32'h8000_0016, 0, "R3 wr2g");
    op(0, 0, 1, 0, 0, 0, 32'hFFFF_FFFF, "R3 2g in");
    op(0, 0, 1, 0, 0, 0, 32'h7FFF_FFFF, "R5 2g out");
    // R3 smallest window 4KB
    op(1, 1, 1, 0, 0, 32'h0ABC_D003, 0, "R3 wr4k");
    op(0, 0, 1, 0, 0, 0, 32'h0ABC_DFFF, "R3 4k in");
    op(0, 0, 1, 0, 0, 0, 32'h0ABC_E000, "R5 4k out");
    // R7 lock: refused secure write, secure read allowed, ns write allowed
    op(1, 1, 1, 0, 1, 32'h5000_0008, 32'h0ABC_D000, "R7 lockwr");
    op(1, 0, 1, 0, 1, 0, 32'h0ABC_D000, "R7 lockrd");
    op(1, 1, 1, 1, 1, 32'h6000_000A, 32'h6000_0000, "R7 nswr");
    // R8 banking: ns copy visible with nonsec, secure copy untouched
    op(1, 0, 1, 1, 0, 0, 32'h6000_0100, "R8 nsrd");
    op(1, 0, 1, 0, 0, 0, 32'h6000_0100, "R8 secrd");
    // R6 unprivileged access
    op(1, 1, 0, 0, 0, 32'hFFFF_F016, 32'h0ABC_D000, "R6 userwr");
    op(1, 0, 0, 1, 0, 0, 32'h6000_0000, "R6 userrd");
    op(1, 0, 1, 0, 0, 0, 32'h0ABC_D000, "R6 after");
    // random mix
    for (int k = 0; k < 400; k++) begin
      c  = ($urandom % 10 == 0) ? 5'($urandom) : 5'(3 + $urandom % 20);
      wd = {$urandom}[31:0];
      wd[4:0] = c;
      if ($urandom % 2) a = {m_base[$urandom % 2], 12'h000} ^ ($urandom & 32'h000F_FFFF);
      else a = $urandom;
      op(($urandom % 8) != 0, $urandom % 2, ($urandom % 5) != 0, $urandom % 2,
         ($urandom % 4) == 0, wd, a, "R5 R6 R7 R8 rand");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule